// File: doc/BRIEF.md
# Shared Power-Control Register Bank with Atomic Bit Aliases

This block holds the control and status words of a power-management region that several bus masters share. A master can replace a whole word with a plain write. It can also change one bit without a read-modify-write sequence. To do that it writes to an aliased address, and the write data names the bit to set or to clear. Two masters that update different bits of the same word therefore cannot undo each other's changes.

The bus has one request cycle and one response cycle. A request is made of select, write enable, address, write data and a secure qualifier. One cycle later the block returns a valid strobe, an error flag and read data. The address space has two parts. The low region carries the alias decoding, requires the secure qualifier for writes, holds read-only status words and has a configurable list of words that refuse aliases. The high region holds plain words with no alias decoding and no secure requirement. Any refused access answers with the error flag. An accepted access answers with the error flag clear.

Top module: `pwr_regbank`

## Requirements
- R1: After reset every writable word reads as zero, and `rsp_valid` is low until an access is made.
- R2: A secure plain write to a writable low word replaces all 32 bits and answers without error. Alias field `bus_addr[15:14]` values 2'b00 and 2'b01 both select a plain access.
- R3: A secure write with `bus_addr[15:14]` = 2'b11 and `bus_addr[16]` = 0 sets bit `bus_wdata[4:0]` of the addressed low word to 1 and leaves the other 31 bits unchanged.
- R4: A secure write with `bus_addr[15:14]` = 2'b10 and `bus_addr[16]` = 0 clears bit `bus_wdata[4:0]` of the addressed low word and leaves the other bits unchanged.
- R5: An aliased write whose data is above 31 answers with an error and leaves the word unchanged.
- R6: Low words flagged in `NOALIAS_MASK` (bit i stands for word i; by default only word 7) refuse aliased writes with an error and still accept plain writes.
- R7: A write to the low region without `bus_secure` answers with an error and changes nothing. Reads succeed with or without `bus_secure`.
- R8: Low words 0 to `NUM_RO`-1 are read-only. Writes to them, plain or aliased, answer with an error. A read returns `stat_in` (word i in bits 32i+31:32i) as registered at the previous clock edge.
- R9: When `bus_addr[16]` = 1 the access targets the high region. There `bus_addr[15:0]` is the plain byte offset, with no alias decoding, and writes are accepted from any master. An address that has bit 15 or bit 14 set in that region is unmapped.
- R10: A low offset that is misaligned or at or beyond `NUM_LO`*4, or a high offset that is misaligned or at or beyond `NUM_HI`*4, is unmapped. Reads and writes there answer with an error and read data zero.
- R11: A read through a set or clear alias address returns the current value of the underlying word and performs no change.
- R12: The response comes exactly one cycle after the request edge. `rsp_valid` is high for one cycle per request, and write responses and error responses carry read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Request strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (17) | Byte address; bit 16 selects the region, bits 15:14 select the alias in the low region |
| bus_wdata | input | 32 | Full word, or bit index for an aliased write |
| bus_secure | input | 1 | Request comes from a secure master |
| stat_in | input | NUM_RO*32 (64) | Status inputs behind the read-only words |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access refused or unmapped |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench uses the default parameters: 8 low words of which 2 are read-only, 4 high words, and an alias-refusal mask that flags only word 7. With these values every kind of refusal can be reached at a small address. That covers a read-only word, a no-alias word, an out-of-range low index (offset 0x20), a high-region address that has the alias bits set, and a misaligned offset. It also places a writable word with aliases between them, so that set and clear can be tested on bit 0, bit 31 and on a bit that already holds the target value.

// File: rtl/rb_pkg.sv
package rb_pkg;
    // Access kind selected by the alias field of a low-region address.
    typedef enum logic [1:0] {
        AK_PLAIN = 2'd0,
        AK_SET   = 2'd1,
        AK_CLR   = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/rb_decode.sv
module rb_decode
    import rb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int NUM_LO = 8,
    parameter int NUM_HI = 4,
    localparam int LO_IDX_W = $clog2(NUM_LO),
    localparam int HI_IDX_W = $clog2(NUM_HI)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hi,
    output logic                mapped,
    output acc_kind_e           kind,
    output logic [LO_IDX_W-1:0] lo_idx,
    output logic [HI_IDX_W-1:0] hi_idx
);
    localparam logic [11:0] LO_LIMIT = 12'(NUM_LO);
    localparam logic [13:0] HI_LIMIT = 14'(NUM_HI);

    logic lo_ok, hi_ok;

    always_comb begin
        hi     = |addr[ADDR_W-1:16];
        lo_idx = addr[2 +: LO_IDX_W];
        hi_idx = addr[2 +: HI_IDX_W];
        lo_ok  = (addr[1:0] == 2'b00) && (addr[13:2] < LO_LIMIT);
        hi_ok  = (addr[1:0] == 2'b00) && (addr[15:2] < HI_LIMIT);
        mapped = hi ? hi_ok : lo_ok;
        kind   = AK_PLAIN;
        if (!hi) begin
            unique case (addr[15:14])
                2'b11:   kind = AK_SET;
                2'b10:   kind = AK_CLR;
                default: kind = AK_PLAIN;
            endcase
        end
    end
endmodule

// File: rtl/rb_guard.sv
module rb_guard
    import rb_pkg::*;
#(
    parameter int NUM_LO = 8,
    parameter int NUM_RO = 2,
    parameter int NUM_HI = 4,
    parameter logic [NUM_LO-1:0] NOALIAS_MASK = 8'h80,
    localparam int LO_IDX_W = $clog2(NUM_LO),
    localparam int HI_IDX_W = $clog2(NUM_HI),
    localparam int NUM_WR = NUM_LO - NUM_RO
) (
    input  logic                sel,
    input  logic                wr,
    input  logic                secure,
    input  logic                idx_ovf,
    input  logic                hi,
    input  logic                mapped,
    input  acc_kind_e           kind,
    input  logic [LO_IDX_W-1:0] lo_idx,
    input  logic [HI_IDX_W-1:0] hi_idx,
    output logic                err,
    output logic [NUM_WR-1:0]   lo_wen,
    output logic [NUM_HI-1:0]   hi_wen
);
    logic is_ro, no_alias, wr_req, lo_bad, wr_bad, rd_bad;

    always_comb begin
        is_ro    = 1'b0;
        no_alias = 1'b0;
        for (int i = 0; i < NUM_LO; i++) begin
            if (lo_idx == LO_IDX_W'(i)) begin
                is_ro    = (i < NUM_RO);
                no_alias = NOALIAS_MASK[i];
            end
        end
        wr_req = sel && wr;
        lo_bad = !secure || is_ro ||
                 ((kind != AK_PLAIN) && (no_alias || idx_ovf));
        wr_bad = wr_req && (!mapped || (!hi && lo_bad));
        rd_bad = sel && !wr && !mapped;
        err    = wr_bad || rd_bad;
    end

    for (genvar g = 0; g < NUM_WR; g++) begin : g_lo_wen
        assign lo_wen[g] = wr_req && !wr_bad && !hi &&
                           (lo_idx == LO_IDX_W'(g + NUM_RO));
    end
    for (genvar h = 0; h < NUM_HI; h++) begin : g_hi_wen
        assign hi_wen[h] = wr_req && !wr_bad && hi && (hi_idx == HI_IDX_W'(h));
    end
endmodule

// File: rtl/rb_store.sv
module rb_store
    import rb_pkg::*;
#(
    parameter int N = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wen,
    input  acc_kind_e           kind,
    input  logic [4:0]          bit_idx,
    input  logic [31:0]         wdata,
    output logic [N-1:0][31:0]  q
);
    logic [31:0] bmask;
    assign bmask = 32'd1 << bit_idx;

    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (wen[i]) begin
                unique case (kind)
                    AK_SET:  q[i] <= q[i] | bmask;
                    AK_CLR:  q[i] <= q[i] & ~bmask;
                    default: q[i] <= wdata;
                endcase
            end
        end

        // R2: a plain write lands the whole data word
        a_r2_full_word: assert property (@(posedge clk) disable iff (!rst_n)
            (wen[i] && kind == AK_PLAIN) |=> q[i] == $past(wdata));
        // R3: set alias raises the indexed bit and keeps the rest
        a_r3_set_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (wen[i] && kind == AK_SET) |=>
                (q[i] == ($past(q[i]) | (32'd1 << $past(bit_idx)))));
        // R4: clear alias drops the indexed bit and keeps the rest
        a_r4_clr_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (wen[i] && kind == AK_CLR) |=>
                (q[i] == ($past(q[i]) & ~(32'd1 << $past(bit_idx)))));
        // R7: a word without write enable holds its value
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wen[i] |=> $stable(q[i]));
    end

    // R2: at most one word is written per request
    a_r2_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));
endmodule

// File: rtl/pwr_regbank.sv
module pwr_regbank
    import rb_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int NUM_LO = 8,
    parameter int NUM_RO = 2,
    parameter int NUM_HI = 4,
    parameter logic [NUM_LO-1:0] NOALIAS_MASK = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_secure,
    input  logic [NUM_RO*32-1:0]  stat_in,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata
);
    localparam int LO_IDX_W = $clog2(NUM_LO);
    localparam int HI_IDX_W = $clog2(NUM_HI);
    localparam int NUM_WR   = NUM_LO - NUM_RO;

    logic                     dec_hi, dec_mapped, acc_err, idx_ovf;
    acc_kind_e                dec_kind;
    logic [LO_IDX_W-1:0]      dec_lo_idx;
    logic [HI_IDX_W-1:0]      dec_hi_idx;
    logic [NUM_WR-1:0]        lo_wen;
    logic [NUM_HI-1:0]        hi_wen;
    logic [NUM_WR-1:0][31:0]  lo_q;
    logic [NUM_HI-1:0][31:0]  hi_q;
    logic [NUM_RO-1:0][31:0]  stat_q;
    logic [31:0]              rd_word;

    assign idx_ovf = |bus_wdata[31:5];

    rb_decode #(.ADDR_W(ADDR_W), .NUM_LO(NUM_LO), .NUM_HI(NUM_HI)) u_dec (
        .addr(bus_addr), .hi(dec_hi), .mapped(dec_mapped), .kind(dec_kind),
        .lo_idx(dec_lo_idx), .hi_idx(dec_hi_idx)
    );

    rb_guard #(.NUM_LO(NUM_LO), .NUM_RO(NUM_RO), .NUM_HI(NUM_HI),
               .NOALIAS_MASK(NOALIAS_MASK)) u_guard (
        .sel(bus_sel), .wr(bus_wr), .secure(bus_secure), .idx_ovf(idx_ovf),
        .hi(dec_hi), .mapped(dec_mapped), .kind(dec_kind),
        .lo_idx(dec_lo_idx), .hi_idx(dec_hi_idx),
        .err(acc_err), .lo_wen(lo_wen), .hi_wen(hi_wen)
    );

    rb_store #(.N(NUM_WR)) u_lo (
        .clk(clk), .rst_n(rst_n), .wen(lo_wen), .kind(dec_kind),
        .bit_idx(bus_wdata[4:0]), .wdata(bus_wdata), .q(lo_q)
    );

    rb_store #(.N(NUM_HI)) u_hi (
        .clk(clk), .rst_n(rst_n), .wen(hi_wen), .kind(AK_PLAIN),
        .bit_idx(bus_wdata[4:0]), .wdata(bus_wdata), .q(hi_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_in;
    end

    always_comb begin
        rd_word = '0;
        if (dec_hi) begin
            for (int i = 0; i < NUM_HI; i++)
                if (dec_hi_idx == HI_IDX_W'(i)) rd_word = hi_q[i];
        end else begin
            for (int i = 0; i < NUM_RO; i++)
                if (dec_lo_idx == LO_IDX_W'(i)) rd_word = stat_q[i];
            for (int i = 0; i < NUM_WR; i++)
                if (dec_lo_idx == LO_IDX_W'(i + NUM_RO)) rd_word = lo_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_sel;
            rsp_err   <= acc_err;
            rsp_rdata <= (bus_sel && !bus_wr && dec_mapped) ? rd_word : 32'd0;
        end
    end

    // R12: one response per request, one cycle later
    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> rsp_valid);
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !rsp_valid);
    // R7: a non-secure write into the low region is refused
    a_r7_nonsecure_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_secure && !(|bus_addr[ADDR_W-1:16]))
            |=> rsp_err);
    // R5: an aliased write with an index above 31 is refused
    a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !(|bus_addr[ADDR_W-1:16]) && bus_addr[15]
            && (|bus_wdata[31:5])) |=> rsp_err);
    // R10: error responses carry no data
    a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));
endmodule

// File: tb/pwr_regbank_test.sv
module pwr_regbank_test;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [16:0] A_SET = 17'h0C000;
    localparam logic [16:0] A_CLR = 17'h08000;
    localparam logic [16:0] A_P01 = 17'h04000;
    localparam logic [16:0] A_HI  = 17'h10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_secure = 1'b0;
    logic [63:0] stat_in = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic        got_valid, got_err;
    logic [31:0] got_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .stat_in(stat_in), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One request; called at a falling edge, returns at the next falling edge.
    task automatic acc(input logic wr, input logic [16:0] a, input logic [31:0] d,
                       input logic sec);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_secure = sec;
        @(negedge clk);
        got_valid = rsp_valid; got_err = rsp_err; got_data = rsp_rdata;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_exp(input string req, input logic [16:0] a, input logic [31:0] d,
                          input logic sec, input logic exp_err);
        acc(1'b1, a, d, sec);
        chk(req, {31'd0, got_err}, {31'd0, exp_err});
    endtask

    task automatic rd_exp(input string req, input logic [16:0] a, input logic sec,
                          input logic exp_err, input logic [31:0] exp_data);
        acc(1'b0, a, 32'd0, sec);
        chk(req, {31'd0, got_err}, {31'd0, exp_err});
        chk(req, got_data, exp_data);
    endtask

    task automatic t_reset();
        chk("R1 idle valid", {31'd0, rsp_valid}, 32'd0);
        rd_exp("R1 reg2 zero", 17'h00008, 1'b0, 1'b0, 32'd0);
        rd_exp("R1 hi reg0 zero", A_HI, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_full();
        wr_exp("R2 full write", 17'h0000C, 32'hA5A5_1234, 1'b1, 1'b0);
        rd_exp("R2 readback", 17'h0000C, 1'b1, 1'b0, 32'hA5A5_1234);
        wr_exp("R2 code01 write", A_P01 | 17'h00010, 32'h0000_1357, 1'b1, 1'b0);
        rd_exp("R2 code01 readback", 17'h00010, 1'b0, 1'b0, 32'h0000_1357);
    endtask

    task automatic t_set();
        wr_exp("R3 base", 17'h0000C, 32'h0000_00F0, 1'b1, 1'b0);
        wr_exp("R3 set b0", A_SET | 17'h0000C, 32'd0, 1'b1, 1'b0);
        rd_exp("R3 after b0", 17'h0000C, 1'b1, 1'b0, 32'h0000_00F1);
        wr_exp("R3 set b31", A_SET | 17'h0000C, 32'd31, 1'b1, 1'b0);
        wr_exp("R3 set b4 again", A_SET | 17'h0000C, 32'd4, 1'b1, 1'b0);
        rd_exp("R3 after b31 b4", 17'h0000C, 1'b1, 1'b0, 32'h8000_00F1);
    endtask

    task automatic t_clr();
        wr_exp("R4 clr b4", A_CLR | 17'h0000C, 32'd4, 1'b1, 1'b0);
        rd_exp("R4 after b4", 17'h0000C, 1'b1, 1'b0, 32'h8000_00E1);
        wr_exp("R4 clr b31", A_CLR | 17'h0000C, 32'd31, 1'b1, 1'b0);
        wr_exp("R4 clr b1 already 0", A_CLR | 17'h0000C, 32'd1, 1'b1, 1'b0);
        rd_exp("R4 after b31", 17'h0000C, 1'b1, 1'b0, 32'h0000_00E1);
    endtask

    task automatic t_bad_index();
        wr_exp("R5 set idx 32", A_SET | 17'h0000C, 32'd32, 1'b1, 1'b1);
        wr_exp("R5 clr idx max", A_CLR | 17'h0000C, 32'hFFFF_FFFF, 1'b1, 1'b1);
        rd_exp("R5 unchanged", 17'h0000C, 1'b1, 1'b0, 32'h0000_00E1);
    endtask

    task automatic t_no_alias();
        wr_exp("R6 full ok", 17'h0001C, 32'h0000_0055, 1'b1, 1'b0);
        wr_exp("R6 set refused", A_SET | 17'h0001C, 32'd1, 1'b1, 1'b1);
        wr_exp("R6 clr refused", A_CLR | 17'h0001C, 32'd0, 1'b1, 1'b1);
        rd_exp("R6 unchanged", 17'h0001C, 1'b1, 1'b0, 32'h0000_0055);
    endtask

    task automatic t_secure();
        wr_exp("R7 nonsecure full", 17'h00014, 32'h1234_5678, 1'b0, 1'b1);
        wr_exp("R7 nonsecure set", A_SET | 17'h00014, 32'd3, 1'b0, 1'b1);
        rd_exp("R7 nonsecure read", 17'h00014, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_read_only();
        stat_in = {32'hC0DE_0001, 32'h0BAD_F00D};
        @(negedge clk);
        rd_exp("R8 ro reg0", 17'h00000, 1'b0, 1'b0, 32'h0BAD_F00D);
        wr_exp("R8 ro write", 17'h00000, 32'hFFFF_FFFF, 1'b1, 1'b1);
        wr_exp("R8 ro set", A_SET | 17'h00004, 32'd9, 1'b1, 1'b1);
        rd_exp("R8 ro reg0 kept", 17'h00000, 1'b1, 1'b0, 32'h0BAD_F00D);
        rd_exp("R8 ro reg1", 17'h00004, 1'b1, 1'b0, 32'hC0DE_0001);
        stat_in[31:0] = 32'h0000_0042;
        @(negedge clk);
        rd_exp("R8 ro tracks input", 17'h00000, 1'b0, 1'b0, 32'h0000_0042);
    endtask

    task automatic t_high();
        wr_exp("R9 hi nonsecure write", A_HI | 17'h00008, 32'hDEAD_BEEF, 1'b0, 1'b0);
        rd_exp("R9 hi readback", A_HI | 17'h00008, 1'b0, 1'b0, 32'hDEAD_BEEF);
        wr_exp("R9 hi alias bits unmapped", A_HI | 17'h0C008, 32'd0, 1'b1, 1'b1);
        rd_exp("R9 hi unchanged", A_HI | 17'h00008, 1'b1, 1'b0, 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped();
        rd_exp("R10 lo beyond", 17'h00020, 1'b1, 1'b1, 32'd0);
        wr_exp("R10 misaligned write", 17'h0000E, 32'hFFFF_FFFF, 1'b1, 1'b1);
        rd_exp("R10 misaligned kept", 17'h0000C, 1'b1, 1'b0, 32'h0000_00E1);
        rd_exp("R10 hi beyond", A_HI | 17'h00010, 1'b1, 1'b1, 32'd0);
    endtask

    task automatic t_alias_read();
        rd_exp("R11 read via set", A_SET | 17'h0000C, 1'b0, 1'b0, 32'h0000_00E1);
        rd_exp("R11 read via clr", A_CLR | 17'h0000C, 1'b0, 1'b0, 32'h0000_00E1);
        rd_exp("R11 no change", 17'h0000C, 1'b0, 1'b0, 32'h0000_00E1);
    endtask

    task automatic t_timing();
        acc(1'b1, 17'h00018, 32'h0000_0777, 1'b1);
        chk("R12 valid after req", {31'd0, got_valid}, 32'd1);
        chk("R12 write data zero", got_data, 32'd0);
        @(negedge clk);
        chk("R12 idle valid low", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_set();
        t_clr();
        t_bad_index();
        t_no_alias();
        t_secure();
        t_read_only();
        t_high();
        t_unmapped();
        t_alias_read();
        t_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule